// File: doc/BRIEF.md
# Recursive Carry-Select Adder

This block is a purely combinational binary adder of parameterised width. It takes two operands and a carry-in and returns their sum and a carry-out. It is built by repeated carry selection. The low half of the operands goes through one half-width adder. The high half goes through two half-width adders, one fed a fixed carry-in of zero and one fed a fixed carry-in of one. The carry leaving the low half then picks, bit by bit through two-input multiplexers, which of the two high-half results becomes the output. The high-half carry is picked the same way.

Every half-width adder is itself made by that same split, halving again at each level until the operands are one bit wide. At that point a full adder forms the bit. The width must be a power of two, and a non-power-of-two value stops elaboration. The block has no clock and holds no state. A result is valid once the inputs have settled through the log2(WIDTH) multiplexer levels.

Top module: `rcs_adder`

## Requirements
- R1: For any operands and carry-in, the concatenation {carry_o, sum_o} equals a_i + b_i + carry_i computed as an unsigned WIDTH+1-bit value.
- R2: With both operands zero and carry_i = 1, sum_o is 1 and carry_o is 0; with carry_i = 0 both outputs are zero.
- R3: An all-ones operand plus zero with carry_i = 1 gives sum_o = 0 and carry_o = 1, so a carry travels across every selection level.
- R4: When b_i is the bitwise complement of a_i, the result is all ones with carry_o = 0 for carry_i = 0, and zero with carry_o = 1 for carry_i = 1.
- R5: Two all-ones operands give carry_o = 1 with sum_o equal to all ones minus one plus carry_i.
- R6: The lower WIDTH/2 bits of sum_o depend only on the lower halves of the operands and on carry_i; changing the upper operand halves leaves them unchanged.
- R7: The same description gives a correct adder at widths 8 and 32, and any WIDTH that is not a power of two is rejected at elaboration.
- R8: The outputs follow the inputs with no clock edge; the result is present a short settling time after the inputs change, and no earlier input history affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder twice, with WIDTH set to 32 and to 8. The 32-bit copy has five levels of selection, so a carry born at bit 0 must pass through every level of the hierarchy, and the half-boundary at bit 16 can be probed on its own. The 8-bit copy is small enough that its overflow and wrap-around cases are hit often by random operands. Having both widths also shows that the recursion ends correctly at two different depths.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // One-bit adder result carried between the leaf and its users
    typedef struct packed {
        logic sum;
        logic carry;
    } bit_res_t;

    // Full adder: parity for the sum, majority for the carry
    function automatic bit_res_t full_add(input logic a, input logic b, input logic c);
        bit_res_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

    // Width legality test used at elaboration
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/csa_full_adder.sv
module csa_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    import rcs_pkg::*;

    bit_res_t res;

    always_comb begin
        res = full_add(a_i, b_i, c_i);
    end

    assign s_o = res.sum;
    assign c_o = res.carry;

endmodule

// File: rtl/csa_mux2.sv
module csa_mux2 #(
    parameter int unsigned W = 1
) (
    input  logic [W-1:0] d0_i,
    input  logic [W-1:0] d1_i,
    input  logic         sel_i,
    output logic [W-1:0] y_o
);
    // Gate-level selector: one shared inverter, two ANDs and one OR per bit
    logic sel_n;
    assign sel_n = ~sel_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic pick0;
        logic pick1;
        assign pick0  = d0_i[i] & sel_n;
        assign pick1  = d1_i[i] & sel_i;
        assign y_o[i] = pick0 | pick1;
    end

endmodule

// File: rtl/csa_node.sv
module csa_node #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    if (W == 1) begin : g_leaf
        csa_full_adder u_fa (
            .a_i (a_i[0]),
            .b_i (b_i[0]),
            .c_i (c_i),
            .s_o (s_o[0]),
            .c_o (c_o)
        );
    end else begin : g_split
        localparam int unsigned H = W / 2;

        logic [H-1:0] lo_sum;
        logic         lo_carry;
        logic [H-1:0] hi0_sum;
        logic         hi0_carry;
        logic [H-1:0] hi1_sum;
        logic         hi1_carry;
        logic [H:0]   picked;

        // Low half sees the real carry-in
        csa_node #(.W(H)) u_lo (
            .a_i (a_i[H-1:0]),
            .b_i (b_i[H-1:0]),
            .c_i (c_i),
            .s_o (lo_sum),
            .c_o (lo_carry)
        );

        // High half, speculating carry-in zero
        csa_node #(.W(H)) u_hi0 (
            .a_i (a_i[W-1:H]),
            .b_i (b_i[W-1:H]),
            .c_i (1'b0),
            .s_o (hi0_sum),
            .c_o (hi0_carry)
        );

        // High half, speculating carry-in one
        csa_node #(.W(H)) u_hi1 (
            .a_i (a_i[W-1:H]),
            .b_i (b_i[W-1:H]),
            .c_i (1'b1),
            .s_o (hi1_sum),
            .c_o (hi1_carry)
        );

        // Low-half carry resolves the speculation for sum and carry alike
        csa_mux2 #(.W(H + 1)) u_sel (
            .d0_i  ({hi0_carry, hi0_sum}),
            .d1_i  ({hi1_carry, hi1_sum}),
            .sel_i (lo_carry),
            .y_o   (picked)
        );

        assign s_o[H-1:0] = lo_sum;
        assign s_o[W-1:H] = picked[H-1:0];
        assign c_o        = picked[H];
    end

endmodule

// File: rtl/rcs_adder.sv
module rcs_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    // R7: only power-of-two widths split evenly down to one bit
    if (!rcs_pkg::is_pow2(WIDTH)) begin : g_bad_width
        $error("rcs_adder: WIDTH must be a power of two");
    end

    csa_node #(.W(WIDTH)) u_root (
        .a_i (a_i),
        .b_i (b_i),
        .c_i (carry_i),
        .s_o (sum_o),
        .c_o (carry_o)
    );

endmodule

// File: rtl/rcs_adder_chk.sv
module rcs_adder_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o
);
    localparam int unsigned HALF = (WIDTH > 1) ? WIDTH / 2 : 1;

    logic [WIDTH:0]  total;
    logic [HALF:0]   low_total;
    logic            known;

    always_comb begin
        total     = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
        low_total = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, carry_i};
        known     = !$isunknown({a_i, b_i, carry_i, sum_o, carry_o});
        if (known) begin
            // R1
            full_sum_chk: assert ({carry_o, sum_o} == total)
                else $error("full sum mismatch");
            // R6
            low_half_chk: assert (sum_o[HALF-1:0] == low_total[HALF-1:0])
                else $error("low half disturbed");
            // R4
            if (b_i == ~a_i) begin
                complement_chk: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}})
                    else $error("complement sum wrong");
            end
            // R5
            if (&a_i && &b_i) begin
                overflow_chk: assert (carry_o && sum_o[WIDTH-1:1] == {(WIDTH-1){1'b1}} && sum_o[0] == carry_i)
                    else $error("overflow result wrong");
            end
            // R2
            if (a_i == '0 && b_i == '0) begin
                zero_operand_chk: assert (!carry_o && sum_o == {{(WIDTH-1){1'b0}}, carry_i})
                    else $error("zero operand result wrong");
            end
        end
    end

endmodule

bind rcs_adder rcs_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/test_rcs_adder.sv
module test_rcs_adder;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [31:0] s;
        logic        co;
    } vec_t;

    // Hand-derived results from the requirements
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0},  // R2
        '{32'h00000000, 32'h00000000, 1'b1, 32'h00000001, 1'b0},  // R2
        '{32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1},  // R3
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFE, 1'b1},  // R5
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1},  // R5
        '{32'hAAAAAAAA, 32'h55555555, 1'b0, 32'hFFFFFFFF, 1'b0},  // R4
        '{32'hAAAAAAAA, 32'h55555555, 1'b1, 32'h00000000, 1'b1},  // R4
        '{32'h0000FFFF, 32'h00000001, 1'b0, 32'h00010000, 1'b0},  // half boundary
        '{32'h12345678, 32'h87654321, 1'b0, 32'h99999999, 1'b0},
        '{32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b1},
        '{32'h7FFFFFFF, 32'h00000000, 1'b1, 32'h80000000, 1'b0},
        '{32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, 32'h55555554, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;

    rcs_adder #(.WIDTH(32)) i_rcs_adder (
        .a_i (a32), .b_i (b32), .carry_i (c32), .sum_o (s32), .carry_o (co32)
    );

    rcs_adder #(.WIDTH(8)) i_rcs_adder_w8 (
        .a_i (a8), .b_i (b8), .carry_i (c8), .sum_o (s8), .carry_o (co8)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        a32 = a; b32 = b; c32 = c;
        #2;
    endtask

    task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
        @(negedge clk);
        a8 = a; b8 = b; c8 = c;
        #2;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R2: zero inputs during reset give a zero result
        chk("R2", {co32, s32}, 33'h0);
        chk("R2", {24'h0, co8, s8}, 33'h0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk (R1; per-entry tags in comments)
        for (int i = 0; i < NV; i++) begin
            drive32(VECS[i].a, VECS[i].b, VECS[i].cin);
            chk("R1", {co32, s32}, {VECS[i].co, VECS[i].s});
        end

        // R3: carry through all levels, 32 and 8 bits
        drive32(32'hFFFFFFFF, 32'h0, 1'b1);
        chk("R3", {co32, s32}, {1'b1, 32'h0});
        drive8(8'hFF, 8'h00, 1'b1);
        chk("R3", {24'h0, co8, s8}, {24'h0, 1'b1, 8'h00});

        // R4: complement pairs at width 8
        drive8(8'h3C, 8'hC3, 1'b0);
        chk("R4", {24'h0, co8, s8}, {24'h0, 1'b0, 8'hFF});
        drive8(8'h3C, 8'hC3, 1'b1);
        chk("R4", {24'h0, co8, s8}, {24'h0, 1'b1, 8'h00});

        // R5: max plus max at width 8
        drive8(8'hFF, 8'hFF, 1'b1);
        chk("R5", {24'h0, co8, s8}, {24'h0, 1'b1, 8'hFF});

        // R6: change only upper halves, low half must hold
        drive32(32'h0000_9F3A, 32'h0000_71C5, 1'b1);
        begin
            logic [15:0] low_ref;
            low_ref = s32[15:0];
            chk("R6", {17'h0, s32[15:0]}, {17'h0, 16'h9F3A + 16'h71C5 + 16'h1});
            drive32(32'hFFFF_9F3A, 32'h1234_71C5, 1'b1);
            chk("R6", {17'h0, s32[15:0]}, {17'h0, low_ref});
        end

        // R8: inputs changed between clock edges, output follows at once
        @(posedge clk);
        #1;
        a32 = 32'h0000_0010; b32 = 32'h0000_0020; c32 = 1'b0;
        #1;
        chk("R8", {co32, s32}, {1'b0, 32'h30});

        // R1: random operands at width 32
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic        rc;
            ra = $urandom(); rb = $urandom(); rc = 1'($urandom());
            if (i % 4 == 0) rb = ~ra;
            drive32(ra, rb, rc);
            chk("R1", {co32, s32}, {1'b0, ra} + {1'b0, rb} + {32'h0, rc});
        end

        // R7: random operands at width 8
        for (int i = 0; i < 300; i++) begin
            logic [7:0] ra, rb;
            logic       rc;
            ra = 8'($urandom()); rb = 8'($urandom()); rc = 1'($urandom());
            drive8(ra, rb, rc);
            chk("R7", {24'h0, co8, s8}, {24'h0, {1'b0, ra} + {1'b0, rb} + {8'h0, rc}});
        end

        summary();
        $finish;
    end

endmodule